// File: doc/BRIEF.md
# Watchdog Timer Peripheral

A watchdog peripheral with two 32-bit registers on a simple register bus. Software loads a countdown value into a timer register. The value reaches the counter after a fixed internal latency. From then on the counter falls by one every clock. It stops when it reaches zero.

Software keeps the system alive by writing the timer register again before the count runs out. If the count falls from one to zero, the block carries out the expiry action selected in the control register:
- nothing;
- raise an ordinary interrupt line;
- raise a non-maskable interrupt line;
- issue a one-cycle chip reset request.

A reset-cause flag records that a watchdog reset request was made. It is cleared only by a dedicated power-on reset input, so it survives the system reset that the request triggers. Software can read it after the restart to tell a watchdog restart from a cold start.

Top module: `wdog_periph`

## Requirements
- R1: After reset the control register reads 0x0000_0000, the timer register reads 0, and `irq_o`, `nmi_o` and `rst_req_o` are low.
- R2: Byte offset 0x0 addresses the control register and offset 0x4 the timer register. The control register reads as the reset-cause flag in bit 31, zeros in bits 30..2, and the action code in bits 1..0. Writes to bits 31..2 are ignored.
- R3: A timer write reaches the counter LOAD_LAT clock edges after the edge that captured it. Before that, a timer read returns the old count.
- R4: The count falls by one per clock while it is non-zero and holds at zero. Loading zero causes no expiry.
- R5: With action code 1, expiry (count going from 1 to 0) raises `irq_o` on the same edge. It stays high until the next timer load reaches the counter.
- R6: With action code 2, expiry raises `nmi_o`. It stays high until the next timer load reaches the counter.
- R7: With action code 3, expiry produces a `rst_req_o` pulse exactly one cycle long and sets the reset-cause flag.
- R8: With action code 0, expiry drives no output.
- R9: A timer reload that reaches the counter before the count gets to zero prevents the expiry action.
- R10: The reset-cause flag keeps its value through `rst` and is cleared only by `por`. `rst` clears the action code to 0.
- R11: The full 32-bit value 0xFFFF_FFFF can be loaded, and it counts down from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset (keeps the reset-cause flag) |
| por | input | 1 | Synchronous active-high power-on reset (clears everything) |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Ordinary interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| rst_req_o | output | 1 | One-cycle chip reset request |

## Verification
The bench hits the load latency at the exact edge. A design that applied the load early or late would show the wrong count in the cycle the old value is due, or would expire one cycle off the predicted edge.

Reloads are placed close to expiry for every action code. A missing keep-alive path would raise an output inside the reload window. Loading zero must not fire an action, which catches a decoder that treats a count of zero as expiry.

The reset-cause flag is checked across a system reset and across a power-on reset. Losing it on `rst` shows up as bit 31 reading 0; keeping it after `por` shows up as bit 31 reading 1. Writes of all-ones to the control register expose any reserved bit that was stored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_DATA_W    = 32;
    localparam int WD_CNT_W     = 32;
    localparam int WD_OFF_CTRL  = 0;
    localparam int WD_OFF_TIMER = 4;
    localparam int WD_FLAG_BIT  = WD_DATA_W - 1;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_NMI   = 2'd2,
        ACT_RESET = 2'd3
    } wd_action_e;

    typedef struct packed {
        logic irq;
        logic nmi;
        logic rst_req;
    } wd_outs_t;

    function automatic logic [WD_DATA_W-1:0] pack_ctrl(input logic flag, input wd_action_e act);
        logic [WD_DATA_W-1:0] w;
        w = '0;
        w[WD_FLAG_BIT] = flag;
        w[1:0] = act;
        return w;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = WD_CNT_W
) (
    input  logic                 clk,
    input  logic                 sys_rst,
    input  logic                 por,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WD_DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]     cnt_i,
    input  logic                 flag_set_i,
    output wd_action_e           act_o,
    output logic                 flag_o,
    output logic                 ld_req_o,
    output logic [CNT_W-1:0]     ld_val_o,
    output logic [WD_DATA_W-1:0] rdata_o
);

    logic hit_ctrl;
    logic hit_timer;
    wd_action_e act_q;
    logic flag_q;

    assign hit_ctrl  = (bus_addr == ADDR_W'(WD_OFF_CTRL));
    assign hit_timer = (bus_addr == ADDR_W'(WD_OFF_TIMER));

    // action code: cleared by either reset
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            act_q <= ACT_NONE;
        end else if (bus_sel && bus_we && hit_ctrl) begin
            act_q <= wd_action_e'(bus_wdata[1:0]);
        end
    end

    // reset-cause flag: power-on domain only
    always_ff @(posedge clk) begin
        if (por) begin
            flag_q <= 1'b0;
        end else if (flag_set_i) begin
            flag_q <= 1'b1;
        end
    end

    assign ld_req_o = bus_sel && bus_we && hit_timer;
    assign ld_val_o = bus_wdata[CNT_W-1:0];
    assign act_o    = act_q;
    assign flag_o   = flag_q;

    always_comb begin
        rdata_o = '0;
        if (bus_sel && !bus_we) begin
            if (hit_ctrl) begin
                rdata_o = pack_ctrl(flag_q, act_q);
            end else if (hit_timer) begin
                rdata_o = WD_DATA_W'(cnt_i);
            end
        end
    end

endmodule

// File: rtl/wdog_ldpipe.sv
module wdog_ldpipe #(
    parameter int CNT_W    = 32,
    parameter int LOAD_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             apply_o,
    output logic [CNT_W-1:0] val_o
);

    generate
        if (LOAD_LAT == 0) begin : g_direct
            assign apply_o = req_i;
            assign val_o   = val_i;
        end else begin : g_stages
            logic [LOAD_LAT-1:0] vld_q;
            logic [CNT_W-1:0]    dat_q [LOAD_LAT];

            for (genvar s = 0; s < LOAD_LAT; s++) begin : g_st
                logic             vld_in;
                logic [CNT_W-1:0] dat_in;
                if (s == 0) begin : g_head
                    assign vld_in = req_i;
                    assign dat_in = val_i;
                end else begin : g_body
                    assign vld_in = vld_q[s-1];
                    assign dat_in = dat_q[s-1];
                end
                always_ff @(posedge clk) begin
                    if (rst) begin
                        vld_q[s] <= 1'b0;
                        dat_q[s] <= '0;
                    end else begin
                        vld_q[s] <= vld_in;
                        dat_q[s] <= dat_in;
                    end
                end
            end

            // the final stage feeds the counter directly, so the load lands
            // LOAD_LAT edges after the capturing edge
            assign apply_o = vld_q[LOAD_LAT-1];
            assign val_o   = dat_q[LOAD_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply_i,
    input  logic [CNT_W-1:0] val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (apply_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // a load arriving on the same edge wins over the last step
    assign expire_o = (cnt_q == ONE) && !apply_i;
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/wdog_act.sv
module wdog_act
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wd_action_e act_i,
    input  logic       expire_i,
    input  logic       clear_i,
    output wd_outs_t   outs_o,
    output logic       flag_set_o
);

    wd_outs_t outs_q;
    logic fire_irq;
    logic fire_nmi;
    logic fire_rst;

    assign fire_irq = expire_i && (act_i == ACT_IRQ);
    assign fire_nmi = expire_i && (act_i == ACT_NMI);
    assign fire_rst = expire_i && (act_i == ACT_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            outs_q <= '0;
        end else begin
            outs_q.rst_req <= fire_rst;
            if (clear_i) begin
                outs_q.irq <= 1'b0;
                outs_q.nmi <= 1'b0;
            end else begin
                if (fire_irq) outs_q.irq <= 1'b1;
                if (fire_nmi) outs_q.nmi <= 1'b1;
            end
        end
    end

    assign outs_o     = outs_q;
    assign flag_set_o = fire_rst;

endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CNT_W    = WD_CNT_W,
    parameter int LOAD_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              rst_req_o
);

    logic             sys_rst;
    wd_action_e       act_q;
    logic             flag_q;
    logic             ld_req;
    logic [CNT_W-1:0] ld_val;
    logic             ld_apply;
    logic [CNT_W-1:0] ld_val_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             flag_set;
    wd_outs_t         outs;

    assign sys_rst = rst || por;

    wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .sys_rst    (sys_rst),
        .por        (por),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_i      (cnt_q),
        .flag_set_i (flag_set),
        .act_o      (act_q),
        .flag_o     (flag_q),
        .ld_req_o   (ld_req),
        .ld_val_o   (ld_val),
        .rdata_o    (bus_rdata)
    );

    wdog_ldpipe #(.CNT_W(CNT_W), .LOAD_LAT(LOAD_LAT)) u_pipe (
        .clk     (clk),
        .rst     (sys_rst),
        .req_i   (ld_req),
        .val_i   (ld_val),
        .apply_o (ld_apply),
        .val_o   (ld_val_q)
    );

    wdog_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (sys_rst),
        .apply_i  (ld_apply),
        .val_i    (ld_val_q),
        .cnt_o    (cnt_q),
        .expire_o (expire)
    );

    wdog_act u_act (
        .clk        (clk),
        .rst        (sys_rst),
        .act_i      (act_q),
        .expire_i   (expire),
        .clear_i    (ld_apply),
        .outs_o     (outs),
        .flag_set_o (flag_set)
    );

    assign irq_o     = outs.irq;
    assign nmi_o     = outs.nmi;
    assign rst_req_o = outs.rst_req;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             por,
    input logic             irq,
    input logic             nmi,
    input logic             rst_req,
    input logic             flag,
    input logic [CNT_W-1:0] cnt,
    input logic             ld_apply,
    input logic [CNT_W-1:0] ld_val,
    input logic [1:0]       act
);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || por)
        rst_req |=> !rst_req); // R7

    AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (por)
        rst_req |-> flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por)
        flag |=> flag); // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || por)
        (!ld_apply && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1)); // R4

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst || por)
        (!ld_apply && cnt == '0) |=> cnt == '0); // R4

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst || por)
        ld_apply |=> cnt == $past(ld_val)); // R3

    AST_OUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst || por)
        $onehot0({irq, nmi, rst_req})); // R5

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst || por)
        $rose(irq) |-> $past(act) == 2'd1); // R5

    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (rst || por)
        $rose(nmi) |-> $past(act) == 2'd2); // R6

    AST_SILENT_NONE: assert property (@(posedge clk) disable iff (rst || por)
        (cnt == CNT_W'(1) && !ld_apply && act == 2'd0) |=> !irq && !nmi && !rst_req); // R8

endmodule

bind wdog_periph wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .por      (por),
    .irq      (irq_o),
    .nmi      (nmi_o),
    .rst_req  (rst_req_o),
    .flag     (flag_q),
    .cnt      (cnt_q),
    .ld_apply (ld_apply),
    .ld_val   (ld_val_q),
    .act      (act_q)
);

// File: tb/wdog_periph_tb.sv
`timescale 1ns/1ps
module wdog_periph_tb;

    localparam int LAT    = 3;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] A_TIMER = 4'h4;

    logic clk = 1'b0;
    logic rst, por;
    logic bus_sel, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic irq_o, nmi_o, rst_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_flag = 1'b0;

    always #10 clk = ~clk;

    wdog_periph #(.ADDR_W(ADDR_W), .CNT_W(32), .LOAD_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .por(por),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [2:0] exp_outs(input int a);
        case (a)
            1: return 3'b100;
            2: return 3'b010;
            3: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [31:0] exp_ctrl(input bit f, input int a);
        return {f, 29'd0, 2'(a)};
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        rst = 1'b1; por = 1'b1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_cyc(3);
        rst = 1'b0; por = 1'b0;
        wait_cyc(1);

        // R1 reset state
        rd(A_CTRL, r);  check("R1 ctrl", r, 32'h0);
        rd(A_TIMER, r); check("R1 timer", r, 32'h0);
        check("R1 outs", {29'd0, irq_o, nmi_o, rst_req_o}, 32'h0);

        // R2 reserved bits and flag bit not writable
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, r); check("R2 ctrl mask", r, 32'h0000_0002);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, r); check("R2 ctrl clear", r, 32'h0);

        // R3 / R11 load latency and full-width value
        wr(A_TIMER, 32'hFFFF_FFFF);
        wait_cyc(LAT - 1);
        rd(A_TIMER, r); check("R3 old count before latency", r, 32'h0);
        wait_cyc(1);
        rd(A_TIMER, r); check("R11 full load", r, 32'hFFFF_FFFF);
        wait_cyc(1);
        rd(A_TIMER, r); check("R11 first step", r, 32'hFFFF_FFFE);

        // R8 action 0: expiry silent
        wr(A_TIMER, 32'd4);
        wait_cyc(LAT + 4);
        rd(A_TIMER, r); check("R4 reaches zero", r, 32'h0);
        check("R8 no action", {29'd0, irq_o, nmi_o, rst_req_o}, 32'h0);
        wait_cyc(2);
        rd(A_TIMER, r); check("R4 holds zero", r, 32'h0);

        // R4 loading zero with IRQ armed gives no expiry
        wr(A_CTRL, 32'd1);
        wr(A_TIMER, 32'd0);
        wait_cyc(LAT + 3);
        check("R4 zero load no irq", {31'd0, irq_o}, 32'h0);
        wr(A_CTRL, 32'd0);

        // randomized reload-then-expire rounds
        for (int it = 0; it < 16; it++) begin
            int a, d, v, v2;
            a  = (it < 4) ? it : int'($urandom_range(0, 3));
            d  = int'($urandom_range(0, 10));
            v  = d + LAT + 2 + int'($urandom_range(0, 30));
            v2 = int'($urandom_range(1, 30));
            wr(A_TIMER, v);
            wait_cyc(LAT);
            check("R5 outs cleared by load", {29'd0, irq_o, nmi_o, rst_req_o}, 32'h0);
            wr(A_CTRL, a);
            for (int k = 0; k < d; k++) begin
                wait_cyc(1);
                check("R9 quiet before reload", {29'd0, irq_o, nmi_o, rst_req_o}, 32'h0);
            end
            wr(A_TIMER, v2);
            for (int k = 0; k < LAT; k++) begin
                wait_cyc(1);
                check("R9 quiet during reload", {29'd0, irq_o, nmi_o, rst_req_o}, 32'h0);
            end
            rd(A_TIMER, r); check("R3 reload landed", r, 32'(v2));
            wait_cyc(v2 - 1);
            rd(A_TIMER, r); check("R4 count at one", r, 32'd1);
            check("R9 quiet at one", {29'd0, irq_o, nmi_o, rst_req_o}, 32'h0);
            wait_cyc(1);
            check("R5 R6 R7 R8 expiry action", {29'd0, irq_o, nmi_o, rst_req_o},
                  {29'd0, exp_outs(a)});
            if (a == 3) exp_flag = 1'b1;
            wait_cyc(1);
            check("R7 pulse ends, R5 R6 levels hold", {29'd0, irq_o, nmi_o, rst_req_o},
                  {29'd0, exp_outs(a) & 3'b110});
            rd(A_CTRL, r); check("R7 flag", r, exp_ctrl(exp_flag, a));
        end

        // R10 flag survives rst, cleared by por
        if (!exp_flag) begin
            wr(A_CTRL, 32'd3);
            wr(A_TIMER, 32'd2);
            wait_cyc(LAT + 3);
            exp_flag = 1'b1;
        end
        rst = 1'b1; wait_cyc(2); rst = 1'b0; wait_cyc(1);
        rd(A_CTRL, r); check("R10 flag kept over rst", r, 32'h8000_0000);
        por = 1'b1; wait_cyc(2); por = 1'b0; wait_cyc(1);
        rd(A_CTRL, r); check("R10 flag cleared by por", r, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule